// File: doc/BRIEF.md
# Chained Interrupt Priority Resolver

This block arbitrates interrupt requests from several peripherals by their position along a priority chain. Each peripheral owns one priority cell. A cell passes a permission signal down the chain to the next cell, which has lower priority. A cell that has a request waiting, or that is being serviced, withholds that permission from every cell below it. All cells drive one shared request line toward the processor. When the processor acknowledges, the single eligible cell presents its vector and enters service. A service-complete pulse releases the chain again.

A higher-priority peripheral can still request and be acknowledged while a lower one is in service, so interrupts nest. A service-complete pulse always ends the innermost level, which is the in-service cell nearest the head of the chain. The chain is a parameterised array of identical cells. A small vector selector gives each cell a fixed even vector for observation.

Top module: `irq_chain_top`

## Requirements
- R1: While `rst` is high at a clock edge, every cell is cleared to idle. After that edge `irq_o` and `vec_valid_o` are 0, and `chain_out` follows `chain_in`.
- R2: If bit i of `req_i` is high at a clock edge while cell i is idle, cell i becomes pending at that edge.
- R3: `irq_o` is high exactly when some cell is pending and its incoming permission is high. A pending cell below a pending or in-service cell does not raise `irq_o`.
- R4: An `ack_i` pulse at a clock edge moves the eligible pending cell into service. From that edge until the next one, `vec_valid_o` is 1 and `vec_o` holds `VEC_BASE + 2*i`. Bit 0 of the vector is therefore 0, and index 0 is the highest priority.
- R5: If no cell is eligible, `ack_i` leaves `vec_valid_o` at 0 after that edge.
- R6: A `done_i` pulse takes out of service only the in-service cell whose incoming permission is high. Any in-service cell lower in the chain stays in service and keeps blocking the cells below it.
- R7: `chain_out` is 1 only when `chain_in` is 1 and no cell is pending or in service.
- R8: A cell above an in-service cell can request and be acknowledged while that lower cell is still in service.
- R9: A request to a cell that is already pending or in service is dropped. Such a cell does not become pending again after its service ends.
- R10: While `chain_in` is 0, `irq_o` stays 0 and `ack_i` selects no vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chain_in | input | 1 | Permission into the head of the chain, normally tied high |
| req_i | input | NCELL | Local request, one bit per cell |
| ack_i | input | 1 | Interrupt acknowledge from the processor |
| done_i | input | 1 | Service-complete pulse |
| irq_o | output | 1 | Shared request, the OR of all eligible cells |
| vec_o | output | VEC_W | Vector of the cell acknowledged at the last edge |
| vec_valid_o | output | 1 | `vec_o` is valid for this cycle |
| chain_out | output | 1 | Permission out of the tail of the chain |

## Verification
The hardest situation to reach from the ports is two nested levels of service with a blocked request waiting below them. The service-complete pulse must then end only the inner level, and the waiting request must stay hidden until the outer level also ends. The stimulus builds this state step by step. It puts a middle cell in service, queues a request at the tail, then raises and acknowledges a request at the head. It then issues service-complete pulses one at a time and checks `irq_o`, `chain_out` and each scoreboarded vector between them.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
  // Each cell owns a vector slot two apart, so bit 0 of every vector is 0.
  localparam int SLOT_STRIDE = 2;

  function automatic int slot_offset(input int idx);
    return idx * SLOT_STRIDE;
  endfunction
endpackage

// File: rtl/irq_cell.sv
module irq_cell (
  input  logic clk,
  input  logic rst,
  input  logic en_in,
  input  logic req,
  input  logic ack,
  input  logic done,
  output logic en_out,
  output logic ask,
  output logic grant
);
  logic pend_q;
  logic svc_q;

  assign ask    = en_in & pend_q;
  assign grant  = ack & en_in & pend_q;
  assign en_out = en_in & ~(pend_q | svc_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      svc_q  <= 1'b0;
    end else if (grant) begin
      pend_q <= 1'b0;
      svc_q  <= 1'b1;
    end else if (done && en_in && svc_q) begin
      svc_q  <= 1'b0;
    end else if (req && !pend_q && !svc_q) begin
      pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_vec_mux.sv
module irq_vec_mux
  import irq_chain_pkg::*;
#(
  parameter int NCELL    = 4,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 64
) (
  input  logic [NCELL-1:0] grant,
  output logic [VEC_W-1:0] vec,
  output logic             any
);
  always_comb begin
    vec = '0;
    any = 1'b0;
    for (int i = NCELL - 1; i >= 0; i--) begin
      if (grant[i]) begin
        vec = VEC_W'(VEC_BASE + slot_offset(i));
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_chain_top.sv
module irq_chain_top #(
  parameter int NCELL    = 4,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chain_in,
  input  logic [NCELL-1:0] req_i,
  input  logic             ack_i,
  input  logic             done_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             vec_valid_o,
  output logic             chain_out
);
  localparam int LINKS = NCELL + 1;

  logic [LINKS-1:0] link;
  logic [NCELL-1:0] ask;
  logic [NCELL-1:0] grant;
  logic [VEC_W-1:0] vec_sel;
  logic             vec_any;
  logic [VEC_W-1:0] vec_q;
  logic             valid_q;

  assign link[0] = chain_in;

  for (genvar g = 0; g < NCELL; g++) begin : g_cell
    irq_cell u_cell (
      .clk    (clk),
      .rst    (rst),
      .en_in  (link[g]),
      .req    (req_i[g]),
      .ack    (ack_i),
      .done   (done_i),
      .en_out (link[g+1]),
      .ask    (ask[g]),
      .grant  (grant[g])
    );
  end

  irq_vec_mux #(
    .NCELL    (NCELL),
    .VEC_W    (VEC_W),
    .VEC_BASE (VEC_BASE)
  ) u_mux (
    .grant (grant),
    .vec   (vec_sel),
    .any   (vec_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= vec_any;
      if (vec_any) vec_q <= vec_sel;
    end
  end

  assign irq_o       = |ask;
  assign chain_out   = link[NCELL];
  assign vec_o       = vec_q;
  assign vec_valid_o = valid_q;
endmodule

// File: rtl/irq_chain_chk.sv
module irq_chain_chk #(
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             chain_in,
  input logic             ack_i,
  input logic             irq_o,
  input logic [VEC_W-1:0] vec_o,
  input logic             vec_valid_o,
  input logic             chain_out
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!irq_o && !vec_valid_o));

  // R4
  ack_vector_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_i && irq_o) |=> (vec_valid_o && !vec_o[0]));

  // R5
  ack_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !irq_o) |=> !vec_valid_o);

  // R7
  chain_block_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> !chain_out);

  // R10
  head_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !chain_in |-> (!irq_o && !chain_out));
endmodule

bind irq_chain_top irq_chain_chk #(.VEC_W(VEC_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .chain_in    (chain_in),
  .ack_i       (ack_i),
  .irq_o       (irq_o),
  .vec_o       (vec_o),
  .vec_valid_o (vec_valid_o),
  .chain_out   (chain_out)
);

// File: tb/irq_chain_top_bench.sv
module irq_chain_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N    = 4;
  localparam int VW   = 8;
  localparam int BASE = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          chain_in = 1'b1;
  logic [N-1:0]  req_i = '0;
  logic          ack_i = 1'b0;
  logic          done_i = 1'b0;
  logic          irq_o;
  logic [VW-1:0] vec_o;
  logic          vec_valid_o;
  logic          chain_out;

  int checks = 0;
  int bad = 0;
  logic [VW-1:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_chain_top #(.NCELL(N), .VEC_W(VW), .VEC_BASE(BASE)) u_irq_chain_top (
    .clk(clk), .rst(rst), .chain_in(chain_in), .req_i(req_i), .ack_i(ack_i),
    .done_i(done_i), .irq_o(irq_o), .vec_o(vec_o), .vec_valid_o(vec_valid_o),
    .chain_out(chain_out)
  );

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_req(input logic [N-1:0] m);
    req_i = m;
    step();
    req_i = '0;
  endtask

  // Driver: push the expected vector, or nothing when no cell is eligible.
  task automatic pulse_ack(input int idx);
    if (idx >= 0) exp_q.push_back(VW'(BASE + 2*idx));
    ack_i = 1'b1;
    step();
    ack_i = 1'b0;
  endtask

  task automatic pulse_done();
    done_i = 1'b1;
    step();
    done_i = 1'b0;
  endtask

  // Monitor: compare every presented vector against the scoreboard.
  always @(negedge clk) begin
    if (!rst && vec_valid_o === 1'b1) begin
      checks++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R5 unexpected vector actual=%0h expected=none", vec_o);
      end else begin
        logic [VW-1:0] e;
        e = exp_q.pop_front();
        if (vec_o !== e) begin
          bad++;
          $display("FAIL R4 vector actual=%0h expected=%0h", vec_o, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    rst = 1'b1;
    step();
    step();
    rst = 1'b0;
    // R1 reset state
    check_bit("R1 irq after reset", irq_o, 1'b0);
    check_bit("R1 valid after reset", vec_valid_o, 1'b0);
    check_bit("R1 chain_out after reset", chain_out, 1'b1);

    // R2 request on cell 2
    pulse_req(4'b0100);
    check_bit("R2 irq after request", irq_o, 1'b1);
    check_bit("R7 chain blocked by pending", chain_out, 1'b0);
    pulse_ack(2);
    check_bit("R4 irq drops after ack", irq_o, 1'b0);
    check_bit("R7 chain blocked by service", chain_out, 1'b0);

    // R3 tail request blocked below in-service cell 2
    pulse_req(4'b1000);
    check_bit("R3 blocked tail request", irq_o, 1'b0);

    // R8 head request nests above cell 2
    pulse_req(4'b0001);
    check_bit("R8 nested irq", irq_o, 1'b1);
    pulse_ack(0);
    check_bit("R8 irq after nested ack", irq_o, 1'b0);

    // R5 ack with nothing eligible
    pulse_ack(-1);
    check_bit("R5 no vector", vec_valid_o, 1'b0);

    // R6 first done ends cell 0 only; cell 2 still blocks cell 3
    pulse_done();
    check_bit("R6 inner level ended only", irq_o, 1'b0);
    check_bit("R6 chain still blocked", chain_out, 1'b0);
    pulse_done();
    check_bit("R6 outer level ended, tail visible", irq_o, 1'b1);
    pulse_ack(3);

    // R9 request to an in-service cell is dropped
    pulse_req(4'b1000);
    pulse_done();
    check_bit("R9 no re-pend after service", irq_o, 1'b0);
    check_bit("R7 chain free", chain_out, 1'b1);

    // R4 priority between simultaneous requests
    pulse_req(4'b1010);
    check_bit("R3 irq with two pending", irq_o, 1'b1);
    pulse_ack(1);
    check_bit("R3 lower pending hidden", irq_o, 1'b0);
    pulse_done();
    check_bit("R6 lower pending now visible", irq_o, 1'b1);
    pulse_ack(3);
    pulse_done();
    check_bit("R7 chain free again", chain_out, 1'b1);

    // R10 head permission low
    chain_in = 1'b0;
    pulse_req(4'b0001);
    check_bit("R10 irq gated", irq_o, 1'b0);
    check_bit("R10 chain_out low", chain_out, 1'b0);
    pulse_ack(-1);
    check_bit("R10 no vector", vec_valid_o, 1'b0);
    chain_in = 1'b1;
    step();
    check_bit("R10 irq after release", irq_o, 1'b1);
    pulse_ack(0);
    pulse_done();
    check_bit("R7 chain idle at end", chain_out, 1'b1);

    step();
    checks++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R4 missing vectors actual=%0d expected=0", exp_q.size());
    end
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule